// File: doc/BRIEF.md
# Majority-Count Weak PUF Key Generator

This block builds a 64-bit device key from the digitized states of a 16-cell resistive array. Each cell reaches the block as one flag, already produced by a comparator outside the block. A flag of 1 means the cell's conductance lies below the fixed reference, so the cell is in its very-high-resistance state. Each challenge is a 16-bit select mask that picks exactly eight cells. The response bit of a challenge is a majority-style vote over the chosen cells: it is set when four or more of them are flagged.

Software first loads 64 select masks into an internal mask file. A start strobe then takes a snapshot of the cell flags. The control state machine walks the challenge index from 0 to 63 and spends two cycles on each challenge. In the COUNT state it registers the population counts. In the DECIDE state it turns the count into a key bit, or it stops the run on a malformed mask. The finished key is committed to the output in a single step, so a run that stops on an error leaves the previous key intact.

The controller has four states. IDLE waits for start. COUNT registers the counts. DECIDE writes the bit. FINISH drives the one-cycle done pulse. The transitions are:
- IDLE→COUNT on start, which also samples the flags.
- COUNT→DECIDE always.
- DECIDE→COUNT when the mask is valid and the index is not the last.
- DECIDE→FINISH on the last index or on a mask error.
- FINISH→IDLE always.

Top module: `puf_keygen`

## Requirements
- R1: After reset, busy, done and err are 0 and key is all zeros. Every mask file entry reads as zero after reset.
- R2: A start seen in IDLE samples cell_flags into a snapshot. Changes on cell_flags after that edge have no effect on the run in progress.
- R3: For a valid challenge, the response bit is 1 when at least 4 cells have both their mask bit and their snapshot flag set. It is 0 otherwise. Mask bit n and flag bit n both refer to cell n, and flag value 1 means very-high resistance.
- R4: Challenge i uses mask file entry i, and its response is placed in key bit i (bit 0 is the LSB), for i from 0 to 63. A write with mask_wr_en high stores mask_wr_data at entry mask_wr_addr.
- R5: busy is high from the cycle after the accepted start for exactly 128 cycles when all masks are valid. done is high for one cycle right after that, and busy is low in that cycle. The new key appears in the same cycle that done is high.
- R6: If entry i, the first malformed entry, does not have exactly 8 bits set, the run stops in its DECIDE cycle. err goes to 1 together with done. done is first seen 2*i+3 cycles after the start edge's cycle. key is not changed. err is cleared by the next accepted start.
- R7: A start pulse while busy is high is ignored. It does not restart or lengthen the run.
- R8: Mask writes while busy is high are ignored.
- R9: key changes only in the cycle where done is high, and it holds its value between runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin key generation (accepted in IDLE) |
| cell_flags | input | 16 | Comparator flag per cell, 1 = very-high resistance |
| mask_wr_en | input | 1 | Write strobe for the mask file |
| mask_wr_addr | input | 6 | Mask file entry to write |
| mask_wr_data | input | 16 | Select mask to store |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| err | output | 1 | Last run stopped on a mask without exactly 8 bits |
| key | output | 64 | Committed key |

## Verification
The bench aims at the vote threshold with flag patterns that give exactly three and exactly four selected cells. A design with an off-by-one threshold would flip those bits. Every run inverts the flags a few cycles after start. A design without a snapshot would then produce a key from the inverted flags.

It pokes start and a mask write into entry 63 in the middle of a run. A design that accepts either one would restart, report a false error or give the wrong length. A malformed mask at entry 10 must stop the run after 23 cycles, set err and keep the old key. A design that commits bit by bit would show a partly overwritten key.

// File: rtl/puf_pkg.sv
package puf_pkg;
    localparam int NUM_CELLS = 16;
    localparam int SEL_CELLS = 8;
    localparam int VOTE_MIN  = 4;
    localparam int NUM_CHAL  = 64;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_COUNT,
        ST_DECIDE,
        ST_FINISH
    } kg_state_e;
endpackage

// File: rtl/puf_popcount.sv
module puf_popcount #(
    parameter int WIDTH = 16,
    localparam int OUT_W = $clog2(WIDTH + 1)
) (
    input  logic [WIDTH-1:0] vec,
    output logic [OUT_W-1:0] count
);
    always_comb begin
        count = '0;
        for (int b = 0; b < WIDTH; b++) begin
            count = count + OUT_W'(vec[b]);
        end
    end
endmodule

// File: rtl/puf_mask_file.sv
module puf_mask_file #(
    parameter int DEPTH = 64,
    parameter int WIDTH = 16,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [AW-1:0]    rd_addr,
    output logic [WIDTH-1:0] rd_data
);
    logic [WIDTH-1:0] entry_q [DEPTH];

    generate
        for (genvar e = 0; e < DEPTH; e++) begin : g_entry
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    entry_q[e] <= '0;
                end else if (wr_en && (wr_addr == AW'(e))) begin
                    entry_q[e] <= wr_data;
                end
            end
        end
    endgenerate

    assign rd_data = entry_q[rd_addr];
endmodule

// File: rtl/puf_keygen.sv
module puf_keygen
    import puf_pkg::*;
#(
    parameter int NCELL    = NUM_CELLS,
    parameter int NSEL     = SEL_CELLS,
    parameter int THRESH   = VOTE_MIN,
    parameter int NUM_CHAL = puf_pkg::NUM_CHAL,
    localparam int IDX_W   = $clog2(NUM_CHAL),
    localparam int CNT_W   = $clog2(NCELL + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [NCELL-1:0]    cell_flags,
    input  logic                mask_wr_en,
    input  logic [IDX_W-1:0]    mask_wr_addr,
    input  logic [NCELL-1:0]    mask_wr_data,
    output logic                busy,
    output logic                done,
    output logic                err,
    output logic [NUM_CHAL-1:0] key
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_CHAL - 1);

    kg_state_e          state_q, state_d;
    logic [NCELL-1:0]   snap_q;
    logic [IDX_W-1:0]   idx_q;
    logic [NCELL-1:0]   cur_mask;
    logic [CNT_W-1:0]   sel_cnt, msk_cnt, sel_cnt_q, msk_cnt_q;
    logic [NUM_CHAL-1:0] work_q, work_d, key_q;
    logic               err_q;
    logic               accept, mask_bad, resp, is_last;

    puf_mask_file #(.DEPTH(NUM_CHAL), .WIDTH(NCELL)) u_masks (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (mask_wr_en && !busy),
        .wr_addr (mask_wr_addr),
        .wr_data (mask_wr_data),
        .rd_addr (idx_q),
        .rd_data (cur_mask)
    );

    puf_popcount #(.WIDTH(NCELL)) u_sel_cnt (.vec(cur_mask & snap_q), .count(sel_cnt));
    puf_popcount #(.WIDTH(NCELL)) u_msk_cnt (.vec(cur_mask),          .count(msk_cnt));

    assign accept   = (state_q == ST_IDLE) && start;
    assign mask_bad = (msk_cnt_q != CNT_W'(NSEL));
    assign resp     = (sel_cnt_q >= CNT_W'(THRESH));
    assign is_last  = (idx_q == LAST_IDX);

    always_comb begin
        work_d        = work_q;
        work_d[idx_q] = resp;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_COUNT;
            ST_COUNT:  state_d = ST_DECIDE;
            ST_DECIDE: state_d = (mask_bad || is_last) ? ST_FINISH : ST_COUNT;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            snap_q    <= '0;
            idx_q     <= '0;
            sel_cnt_q <= '0;
            msk_cnt_q <= '0;
            work_q    <= '0;
            key_q     <= '0;
            err_q     <= 1'b0;
        end else begin
            if (accept) begin
                snap_q <= cell_flags;
                idx_q  <= '0;
                err_q  <= 1'b0;
            end
            if (state_q == ST_COUNT) begin
                sel_cnt_q <= sel_cnt;
                msk_cnt_q <= msk_cnt;
            end
            if (state_q == ST_DECIDE) begin
                if (mask_bad) begin
                    err_q <= 1'b1;
                end else begin
                    work_q <= work_d;
                    if (is_last) key_q <= work_d;
                    else         idx_q <= idx_q + 1'b1;
                end
            end
        end
    end

    // outputs
    always_comb begin
        busy = (state_q == ST_COUNT) || (state_q == ST_DECIDE);
        done = (state_q == ST_FINISH);
        err  = err_q;
        key  = key_q;
    end
endmodule

// File: rtl/puf_keygen_chk.sv
module puf_keygen_chk #(
    parameter int NUM_CHAL = 64,
    localparam int CW = $clog2(2 * NUM_CHAL + 2)
) (
    input logic                clk,
    input logic                rst_n,
    input logic                start,
    input logic                busy,
    input logic                done,
    input logic                err,
    input logic [NUM_CHAL-1:0] key
);
    logic [CW-1:0] run_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    run_cnt <= '0;
        else if (busy) run_cnt <= run_cnt + 1'b1;
        else if (!done) run_cnt <= '0;
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R5
    AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done)); // R5
    AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start)); // R2
    AST_RUN_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !err) |-> (run_cnt == CW'(2 * NUM_CHAL))); // R5
    AST_KEY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(key) |-> done); // R9
    AST_ERR_KEEPS_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err) |-> $stable(key)); // R6
    AST_ERR_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> done); // R6
endmodule

bind puf_keygen puf_keygen_chk #(.NUM_CHAL(NUM_CHAL)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
    .done(done), .err(err), .key(key)
);

// File: tb/puf_keygen_test.sv
`timescale 1ns/1ps
module puf_keygen_test;
    typedef struct packed {
        logic [63:0] key;
        logic        err;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] cell_flags = '0;
    logic        mask_wr_en = 1'b0;
    logic [5:0]  mask_wr_addr = '0;
    logic [15:0] mask_wr_data = '0;
    logic        busy, done, err;
    logic [63:0] key;

    int checks = 0;
    int fails  = 0;
    exp_t exp_q[$];
    logic [15:0] model_mask [64];
    logic [63:0] model_key = '0;
    bit finished = 0;

    puf_keygen uut (
        .clk(clk), .rst_n(rst_n), .start(start), .cell_flags(cell_flags),
        .mask_wr_en(mask_wr_en), .mask_wr_addr(mask_wr_addr),
        .mask_wr_data(mask_wr_data), .busy(busy), .done(done),
        .err(err), .key(key)
    );

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    function automatic int pc16(input logic [15:0] v);
        int n = 0;
        for (int b = 0; b < 16; b++) n += int'(v[b]);
        return n;
    endfunction

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    // monitor: compare each done against the scoreboard
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R5 unexpected done", 64'(done), 64'd0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(key == e.key, "R3/R4 key", key, e.key);
                check(err == e.err, "R6 err", 64'(err), 64'(e.err));
            end
        end
    end

    task automatic write_mask(input int addr, input logic [15:0] data);
        @(negedge clk);
        mask_wr_en = 1'b1; mask_wr_addr = 6'(addr); mask_wr_data = data;
        @(negedge clk);
        mask_wr_en = 1'b0;
        model_mask[addr] = data;
    endtask

    // driver: compute expected result, push, run, check timing
    task automatic run(input logic [15:0] flags, input bit poke_start, input bit poke_wr);
        exp_t e;
        int bad = -1;
        int exp_len;
        int k;
        e.key = model_key; e.err = 1'b0;
        for (int i = 0; i < 64; i++) begin
            if (bad < 0 && pc16(model_mask[i]) != 8) bad = i;
        end
        if (bad >= 0) begin
            e.err = 1'b1;
            exp_len = 2 * bad + 3;
        end else begin
            for (int i = 0; i < 64; i++)
                e.key[i] = (pc16(model_mask[i] & flags) >= 4); // R3 threshold
            model_key = e.key;
            exp_len = 129;
        end
        exp_q.push_back(e);
        @(negedge clk);
        cell_flags = flags; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        k = 1;
        check(busy == 1'b1, "R5 busy after start", 64'(busy), 64'd1);
        check(err == 1'b0, "R6 err cleared by start", 64'(err), 64'd0);
        while (!done && k < 400) begin
            if (k == 3) cell_flags = ~flags;                 // R2 snapshot
            if (k == 40 && poke_start) start = 1'b1;         // R7
            if (k == 41) start = 1'b0;
            if (k == 50 && poke_wr) begin                    // R8
                mask_wr_en = 1'b1; mask_wr_addr = 6'd63; mask_wr_data = 16'h0001;
            end
            if (k == 51) mask_wr_en = 1'b0;
            @(negedge clk);
            k++;
        end
        check(k == exp_len, "R5/R6 run length", 64'(k), 64'(exp_len));
        check(busy == 1'b0, "R5 busy low at done", 64'(busy), 64'd0);
        @(negedge clk);
        check(done == 1'b0, "R5 done one cycle", 64'(done), 64'd0);
        repeat (4) @(negedge clk);
        check(key == model_key, "R9 key held", key, model_key);
    endtask

    initial begin
        #2000000;
        checks++; fails++;
        $display("FAIL watchdog expired actual=hang expected=finish");
        report();
    end

    initial begin
        logic [15:0] bases [4];
        bases[0] = 16'h00FF; bases[1] = 16'h5555; bases[2] = 16'h0F0F; bases[3] = 16'h3C3C;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(busy == 1'b0, "R1 busy", 64'(busy), 64'd0);
        check(done == 1'b0, "R1 done", 64'(done), 64'd0);
        check(err == 1'b0, "R1 err", 64'(err), 64'd0);
        check(key == 64'd0, "R1 key", key, 64'd0);
        rst_n = 1'b1;
        for (int i = 0; i < 64; i++) model_mask[i] = 16'h0000;
        // R1 empty mask file: entry 0 malformed -> error at once, key kept
        run(16'hFFFF, 0, 0);
        // R4 load masks
        for (int i = 0; i < 64; i++) begin
            logic [15:0] b;
            int r;
            b = bases[i / 16];
            r = i % 16;
            write_mask(i, (b << r) | (b >> (16 - r)));
        end
        run(16'h0000, 0, 0);   // R3 all clear
        run(16'hFFFF, 0, 0);   // R3 all set
        run(16'h000F, 0, 0);   // R3 count of 4 on some masks
        run(16'h0007, 0, 0);   // R3 count of 3 boundary
        run(16'hA5C3, 1, 0);   // R7 start poke
        run(16'h3C96, 0, 1);   // R8 write poke
        // R6 malformed entry 10
        write_mask(10, 16'h007F);
        run(16'h1234, 0, 0);
        write_mask(10, 16'h01FF);
        run(16'h1234, 0, 0);
        write_mask(10, 16'h00FF);
        run(16'h5A0F, 0, 0);   // R6 err cleared, R4 good run
        check(exp_q.size() == 0, "R5 all results seen", 64'(exp_q.size()), 64'd0);
        report();
    end
endmodule